// File: doc/BRIEF.md
# Load-Use Hazard Stall Detector

This block sits in the decode stage of a five-stage, in-order pipeline. It decides whether the instruction in decode may advance. The one case it guards against is a load in the execute stage whose destination register is read by the instruction right behind it. The loaded value only exists after the memory stage, so the dependent instruction must wait one cycle. After that wait it can take the value through the forwarding paths.

The decision is purely combinational from the current-cycle inputs, and it drives three outputs:
- **Program-counter write enable:** lowered during a stall so that no new instruction is fetched.
- **Fetch/decode register write enable:** lowered during a stall so that the decoded instruction is held.
- **Bubble select:** raised during a stall so that the control bundle entering the decode/execute register is forced to all zeros. The stalled slot then behaves as a no-op while the load itself carries on.

A comparison only counts when the decode instruction actually reads that source. A destination of register zero never causes a stall. A register written in writeback and read in decode in the same cycle needs no stall, so the block looks at the execute stage only.

Top module: `lu_hazard_unit`

## Requirements
- R1: When `exe_load` is 1, `exe_dst` is non-zero, and either (`dec_use_a` is 1 and `dec_src_a` equals `exe_dst`) or (`dec_use_b` is 1 and `dec_src_b` equals `exe_dst`), the block stalls in the same cycle.
- R2: When `exe_load` is 0, the block never stalls, whatever the register fields hold.
- R3: When `exe_dst` is 0, the block never stalls, even if a used source field is also 0 and `exe_load` is 1.
- R4: A source whose use flag is 0 is ignored: a match on that field alone causes no stall.
- R5: While stalling, `pc_wr_en`=0, `fd_wr_en`=0 and `ctrl_zero`=1. In every other cycle, `pc_wr_en`=1, `fd_wr_en`=1 and `ctrl_zero`=0.
- R6: The outputs depend only on the current inputs, with no internal state. Once the bubble occupies execute (`exe_load`=0 in the next cycle) with the decode instruction held, the stall clears, so a load-use pair costs exactly one bubble.
- R7: When both used sources match the load target, the outputs are the same single-stall outputs as for one match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| exe_load | input | 1 | Memory-read control of the instruction in execute |
| exe_dst | input | AW (5) | Destination register of the instruction in execute |
| dec_src_a | input | AW (5) | First source register field of the instruction in decode |
| dec_src_b | input | AW (5) | Second source register field of the instruction in decode |
| dec_use_a | input | 1 | Decode instruction reads its first source |
| dec_use_b | input | 1 | Decode instruction reads its second source |
| pc_wr_en | output | 1 | Program-counter write enable (0 holds the PC) |
| fd_wr_en | output | 1 | Fetch/decode register write enable (0 holds the instruction) |
| ctrl_zero | output | 1 | Forces the control bundle entering decode/execute to zero |

## Verification
Every output of this block is due in the same cycle as its inputs, because no register lies on any path. The bench therefore drives the inputs on the falling clock edge and compares all three outputs a short settle time later, before the next rising edge. The one-bubble release in R6 is due one clock after the stall. To check it, a small execute-stage model in the bench is advanced on the rising edge using the stall outputs: it takes a bubble or the decoded instruction. The stall-cycle count is then compared when the dependent instruction finally advances.

// File: rtl/lu_hazard_pkg.sv
package lu_hazard_pkg;

  // Control outputs of the hazard unit, grouped as one bundle
  typedef struct packed {
    logic pc_wr;
    logic fd_wr;
    logic zero_ctl;
  } hz_ctl_t;

  localparam hz_ctl_t HZ_RUN  = '{pc_wr: 1'b1, fd_wr: 1'b1, zero_ctl: 1'b0};
  localparam hz_ctl_t HZ_HOLD = '{pc_wr: 1'b0, fd_wr: 1'b0, zero_ctl: 1'b1};

endpackage

// File: rtl/lu_src_cmp.sv
// Compares one decode source field with the execute-stage destination.
// A field that the decode instruction does not read never matches.
module lu_src_cmp #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          used,
  input  logic [AW-1:0] dst,
  output logic          hit
);

  always_comb begin
    hit = used && (src == dst);
  end

endmodule

// File: rtl/lu_stall_eval.sv
// Reduces the per-source hits into one stall decision. Only a load in
// execute with a real (non-zero) destination can cause a stall.
module lu_stall_eval #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic            is_load,
  input  logic [AW-1:0]   dst,
  input  logic [NSRC-1:0] hits,
  output logic            stall
);

  logic dst_live;
  logic any_hit;

  always_comb begin
    dst_live = (dst != '0);
    any_hit  = |hits;
    stall    = is_load && dst_live && any_hit;
  end

endmodule

// File: rtl/lu_ctl_gen.sv
// Turns the stall decision into the enable and bubble controls.
module lu_ctl_gen
  import lu_hazard_pkg::*;
(
  input  logic    stall,
  output hz_ctl_t ctl
);

  always_comb begin
    if (stall) ctl = HZ_HOLD;
    else       ctl = HZ_RUN;
  end

endmodule

// File: rtl/lu_hazard_unit.sv
module lu_hazard_unit
  import lu_hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          exe_load,
  input  logic [AW-1:0] exe_dst,
  input  logic [AW-1:0] dec_src_a,
  input  logic [AW-1:0] dec_src_b,
  input  logic          dec_use_a,
  input  logic          dec_use_b,
  output logic          pc_wr_en,
  output logic          fd_wr_en,
  output logic          ctrl_zero
);

  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] src_vec;
  logic [NSRC-1:0]         use_vec;
  logic [NSRC-1:0]         hit_vec;
  logic                    stall;
  hz_ctl_t                 ctl;

  always_comb begin
    src_vec[0] = dec_src_a;
    src_vec[1] = dec_src_b;
    use_vec[0] = dec_use_a;
    use_vec[1] = dec_use_b;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    lu_src_cmp #(.AW(AW)) u_cmp (
      .src  (src_vec[g]),
      .used (use_vec[g]),
      .dst  (exe_dst),
      .hit  (hit_vec[g])
    );
  end

  lu_stall_eval #(.AW(AW), .NSRC(NSRC)) u_eval (
    .is_load (exe_load),
    .dst     (exe_dst),
    .hits    (hit_vec),
    .stall   (stall)
  );

  lu_ctl_gen u_ctl (
    .stall (stall),
    .ctl   (ctl)
  );

  always_comb begin
    pc_wr_en  = ctl.pc_wr;
    fd_wr_en  = ctl.fd_wr;
    ctrl_zero = ctl.zero_ctl;
  end

endmodule

// File: rtl/lu_hazard_chk.sv
module lu_hazard_chk #(
  parameter int AW = 5
) (
  input logic          exe_load,
  input logic [AW-1:0] exe_dst,
  input logic [AW-1:0] dec_src_a,
  input logic [AW-1:0] dec_src_b,
  input logic          dec_use_a,
  input logic          dec_use_b,
  input logic          pc_wr_en,
  input logic          fd_wr_en,
  input logic          ctrl_zero
);

  always_comb begin
    // R2
    stall_needs_load_chk: assert (!ctrl_zero || exe_load)
      else $error("bubble without a load in execute");
    // R3
    zero_dst_quiet_chk: assert (!ctrl_zero || (exe_dst != '0))
      else $error("bubble for register zero");
    // R4
    unused_src_quiet_chk: assert (!ctrl_zero ||
                                  (dec_use_a && dec_src_a == exe_dst) ||
                                  (dec_use_b && dec_src_b == exe_dst))
      else $error("bubble without a used matching source");
    // R5
    enables_agree_chk: assert ((pc_wr_en == fd_wr_en) && (ctrl_zero == !pc_wr_en))
      else $error("enables and bubble disagree");
    // R1
    load_use_seen_chk: assert (!(exe_load && exe_dst != '0 &&
                                 dec_use_a && dec_src_a == exe_dst) || ctrl_zero)
      else $error("missed load-use on first source");
  end

endmodule

bind lu_hazard_unit lu_hazard_chk #(.AW(AW)) u_chk (
  .exe_load  (exe_load),
  .exe_dst   (exe_dst),
  .dec_src_a (dec_src_a),
  .dec_src_b (dec_src_b),
  .dec_use_a (dec_use_a),
  .dec_use_b (dec_use_b),
  .pc_wr_en  (pc_wr_en),
  .fd_wr_en  (fd_wr_en),
  .ctrl_zero (ctrl_zero)
);

// File: tb/sim_lu_hazard_unit.sv
`timescale 1ns/1ps
module sim_lu_hazard_unit;

  localparam int AW = 5;

  logic          clk;
  logic          rst_n;
  logic          exe_load;
  logic [AW-1:0] exe_dst;
  logic [AW-1:0] dec_src_a;
  logic [AW-1:0] dec_src_b;
  logic          dec_use_a;
  logic          dec_use_b;
  logic          pc_wr_en;
  logic          fd_wr_en;
  logic          ctrl_zero;

  int n_cmp;
  int n_bad;
  int cyc;
  bit done;

  lu_hazard_unit #(.AW(AW)) u0 (
    .exe_load  (exe_load),
    .exe_dst   (exe_dst),
    .dec_src_a (dec_src_a),
    .dec_src_b (dec_src_b),
    .dec_use_a (dec_use_a),
    .dec_use_b (dec_use_b),
    .pc_wr_en  (pc_wr_en),
    .fd_wr_en  (fd_wr_en),
    .ctrl_zero (ctrl_zero)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Expected stall decision computed from the requirement text
  function automatic bit exp_stall(bit ld, logic [AW-1:0] d,
                                   logic [AW-1:0] a, bit ua,
                                   logic [AW-1:0] b, bit ub);
    bit m;
    m = (ua && a == d) || (ub && b == d);
    return ld && (d != 0) && m;
  endfunction

  task automatic check_out(bit st, string req);
    bit ep, ef, ez;
    ep = !st; ef = !st; ez = st;
    n_cmp++;
    if (pc_wr_en !== ep || fd_wr_en !== ef || ctrl_zero !== ez) begin
      n_bad++;
      $display("FAIL %s: got pc=%b fd=%b zero=%b expected pc=%b fd=%b zero=%b",
               req, pc_wr_en, fd_wr_en, ctrl_zero, ep, ef, ez);
    end
  endtask

  task automatic apply(bit ld, logic [AW-1:0] d, logic [AW-1:0] a, bit ua,
                       logic [AW-1:0] b, bit ub, string req);
    @(negedge clk);
    exe_load = ld; exe_dst = d;
    dec_src_a = a; dec_use_a = ua;
    dec_src_b = b; dec_use_b = ub;
    #2;
    check_out(exp_stall(ld, d, a, ua, b, ub), req);
  endtask

  // Small execute-stage model: count bubbles before decode advances (R6)
  task automatic pipe_run(logic [AW-1:0] ld_dst, logic [AW-1:0] a, bit ua,
                          logic [AW-1:0] b, bit ub, int exp_bubbles);
    bit m_load;
    logic [AW-1:0] m_dst;
    int bubbles;
    bit advanced;
    m_load = 1'b1; m_dst = ld_dst; bubbles = 0; advanced = 1'b0;
    for (int k = 0; k < 4 && !advanced; k++) begin
      @(negedge clk);
      exe_load = m_load; exe_dst = m_dst;
      dec_src_a = a; dec_use_a = ua;
      dec_src_b = b; dec_use_b = ub;
      #2;
      check_out(exp_stall(m_load, m_dst, a, ua, b, ub), "R6 pipe step");
      @(posedge clk);
      if (ctrl_zero) begin
        bubbles++;
        m_load = 1'b0; m_dst = '0;
      end else begin
        advanced = 1'b1;
      end
    end
    n_cmp++;
    if (bubbles != exp_bubbles || !advanced) begin
      n_bad++;
      $display("FAIL R6: bubbles=%0d advanced=%0b expected bubbles=%0d advanced=1",
               bubbles, advanced, exp_bubbles);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    n_cmp = 0; n_bad = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0;
    exe_load = 1'b0; exe_dst = '0;
    dec_src_a = '0; dec_src_b = '0; dec_use_a = 1'b0; dec_use_b = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Idle state after reset: free running (R5)
    #1; check_out(1'b0, "R5 idle");

    // R1: load target matches first or second used source
    apply(1, 5'd6, 5'd6, 1, 5'd4, 1, "R1 src a");
    apply(1, 5'd9, 5'd3, 1, 5'd9, 1, "R1 src b");
    apply(1, 5'd31, 5'd31, 1, 5'd0, 0, "R1 top reg");
    // R5: no match gives free running outputs
    apply(1, 5'd6, 5'd7, 1, 5'd8, 1, "R5 no match");
    // R2: not a load
    apply(0, 5'd6, 5'd6, 1, 5'd6, 1, "R2 non-load");
    // R3: register zero
    apply(1, 5'd0, 5'd0, 1, 5'd0, 1, "R3 zero dst");
    // R4: match only on unused fields
    apply(1, 5'd12, 5'd12, 0, 5'd1, 1, "R4 a unused");
    apply(1, 5'd12, 5'd2, 1, 5'd12, 0, "R4 b unused");
    apply(1, 5'd12, 5'd12, 0, 5'd12, 0, "R4 both unused");
    // R7: both sources match
    apply(1, 5'd10, 5'd10, 1, 5'd10, 1, "R7 double");
    // R6: exactly one bubble for a load-use pair, none otherwise
    pipe_run(5'd6, 5'd6, 1, 5'd4, 1, 1);
    pipe_run(5'd7, 5'd7, 1, 5'd7, 1, 1);
    pipe_run(5'd7, 5'd1, 1, 5'd2, 1, 0);

    // Random stimulus with biased matches (R1 R2 R3 R4)
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] d, a, b;
      bit ld, ua, ub;
      d  = AW'($urandom_range(0, 7));
      a  = ($urandom_range(0, 1) == 1) ? d : AW'($urandom_range(0, 31));
      b  = ($urandom_range(0, 2) == 0) ? d : AW'($urandom_range(0, 31));
      ld = ($urandom_range(0, 3) != 0);
      ua = ($urandom_range(0, 3) != 0);
      ub = ($urandom_range(0, 1) == 1);
      apply(ld, d, a, ua, b, ub, "R1 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule